// File: doc/BRIEF.md
# Indexed-Register Blit Address Sequencer

This block is the control and addressing core of a two-dimensional block-transfer engine. Software drives it through a single 16-bit write port. The upper four bits of every written word pick an internal register, and the lower twelve bits are the value stored there. The registers hold a source start address and a destination start address, each split into a low half and a high half. They also hold a width in pixels, a height in rows, a row pitch, and two control words.

Once started, the sequencer offers one source/destination address pair per step on a valid/ready handshake and walks both sides across the rectangle. The walk runs forward, with addresses rising, or in reverse, with addresses falling. Each side is either rectangular, jumping by the pitch from the start of one row to the start of the next, or linear, running on contiguously across row boundaries. When the walk ends, the busy indication drops. If enabled, the destination registers are rewritten with the address following the final pixel, and a sticky interrupt is raised.

Top module: `blitSeq`

## Requirements
- R1: A write stores bits 11:0 of `wrData` into the register selected by bits 15:12. The registers are: 0 control A, 1 control B, 2/3 source low/high, 4/5 destination low/high, 6 width, 7 height, 8 pitch. Indices 9 to 15 are ignored and read as zero. `rdData` returns the stored 12 bits of the register addressed by `rdIdx`.
- R2: Writing control A with bit 11 set while idle starts a walk. `busy` is 1 from the cycle after that write until the cycle after the last step is accepted. Bit 11 of control A reads back as `busy`.
- R3: Forward walk with both sides rectangular: step k has column c = k mod width and row r = k div width, and each side presents start + r*pitch + c. The full 24-bit address is {high, low}, and arithmetic wraps at 24 bits.
- R4: When control A bit 10 is set, the walk is reversed: each side presents start - (r*pitch + c), or start - k if that side is linear.
- R5: Control A bit 7 makes the destination linear and bit 6 makes the source linear. A linear side presents start ± k, independent of pitch.
- R6: When control B bit 7 is set, a write to the destination high register while idle starts the walk. When that bit is clear, the same write does not start one.
- R7: When control B bit 6 is set, the destination registers hold the final destination address ±1 (in the walk direction) after a walk completes. Otherwise they keep their written values.
- R8: When control B bit 10 is set, `irq` rises when a transfer finishes and stays high until `irqAck` is pulsed.
- R9: While `busy` is 1, writes to any register other than control A are ignored.
- R10: A start with width or height equal to zero completes within two cycles and never asserts `memValid`.
- R11: Exactly width*height steps are offered. While `memValid` is 1 and `memReady` is 0, both addresses hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register index (15:12) and payload (11:0) |
| rdIdx | input | 4 | Register index to read |
| rdData | output | 12 | Read value of the selected register |
| memValid | output | 1 | An address pair is offered |
| memReady | input | 1 | The offered pair is taken this cycle |
| srcAddr | output | 24 | Source address of the current step |
| dstAddr | output | 24 | Destination address of the current step |
| busy | output | 1 | A transfer is pending or running |
| irq | output | 1 | Sticky completion interrupt |
| irqAck | input | 1 | Clears `irq` |

## Verification
A corrupted row counter or column counter appears at the address ports within one row. It shows as a pitch jump in the wrong column, or as a step count that differs from width times height when `busy` falls. A wrong direction or linear flag, or a wrong row base, misplaces the first address after a row boundary, one accepted step after the fault. Faults in register decoding or in the busy guard appear at the next read-back of the destination or dimension registers after the walk, or as a missing or spurious `irq`.

// File: rtl/blitSeqPkg.sv
package blitSeqPkg;
  localparam int IDX_W = 4;
  localparam int NUM_REGS = 9;

  localparam logic [IDX_W-1:0] IX_CTLA  = 4'd0;
  localparam logic [IDX_W-1:0] IX_CTLB  = 4'd1;
  localparam logic [IDX_W-1:0] IX_SRCLO = 4'd2;
  localparam logic [IDX_W-1:0] IX_SRCHI = 4'd3;
  localparam logic [IDX_W-1:0] IX_DSTLO = 4'd4;
  localparam logic [IDX_W-1:0] IX_DSTHI = 4'd5;
  localparam logic [IDX_W-1:0] IX_WIDTH = 4'd6;
  localparam logic [IDX_W-1:0] IX_HEIGHT = 4'd7;
  localparam logic [IDX_W-1:0] IX_PITCH = 4'd8;

  // control A bit positions (go must be the top bit of the payload)
  localparam int CA_GO   = 11;
  localparam int CA_REV  = 10;
  localparam int CA_DLIN = 7;
  localparam int CA_SLIN = 6;
  // control B bit positions
  localparam int CB_IRQEN = 10;
  localparam int CB_QUICK = 7;
  localparam int CB_UPD   = 6;

  typedef struct packed {
    logic load;
    logic advance;
  } walkCmd_t;
endpackage

// File: rtl/blitSide.sv
module blitSide #(
  parameter int REG_W  = 12,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              advance,
  input  logic              rowEnd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              linear,
  input  logic              reverse,
  input  logic [REG_W-1:0]  pitch,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] stepAddr
);
  logic [ADDR_W-1:0] curQ, rowQ, rowNext, pitchExt;

  always_comb begin
    pitchExt = ADDR_W'(pitch);
    stepAddr = reverse ? curQ - 1'b1 : curQ + 1'b1;
    rowNext  = reverse ? rowQ - pitchExt : rowQ + pitchExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ <= '0;
      rowQ <= '0;
    end else if (load) begin
      curQ <= startAddr;
      rowQ <= startAddr;
    end else if (advance) begin
      if (rowEnd && !linear) begin
        curQ <= rowNext;
        rowQ <= rowNext;
      end else begin
        curQ <= stepAddr;
      end
    end
  end

  assign curAddr = curQ;
endmodule

// File: rtl/blitWalk.sv
module blitWalk import blitSeqPkg::*; #(
  parameter int REG_W  = 12,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic [REG_W-1:0]  dimX,
  input  logic [REG_W-1:0]  dimY,
  input  logic [REG_W-1:0]  pitch,
  input  logic              reverse,
  input  logic              srcLin,
  input  logic              dstLin,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              lastStep,
  output logic [ADDR_W-1:0] endDst
);
  localparam int SIDES = 2;

  logic [REG_W-1:0] widthQ, pitchQ, xCnt, yCnt;
  logic revQ, srcLinQ, dstLinQ, active, rowEnd;
  logic [ADDR_W-1:0] startArr [SIDES];
  logic [ADDR_W-1:0] curArr   [SIDES];
  logic [ADDR_W-1:0] stepArr  [SIDES];
  logic              linArr   [SIDES];

  always_comb begin
    startArr[0] = srcStart;
    startArr[1] = dstStart;
    linArr[0]   = srcLinQ;
    linArr[1]   = dstLinQ;
    rowEnd      = (xCnt == widthQ - 1'b1);
    lastStep    = active && rowEnd && (yCnt == REG_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthQ <= '0; pitchQ <= '0; xCnt <= '0; yCnt <= '0;
      revQ <= 1'b0; srcLinQ <= 1'b0; dstLinQ <= 1'b0; active <= 1'b0;
    end else if (cmd.load) begin
      widthQ  <= dimX;
      pitchQ  <= pitch;
      revQ    <= reverse;
      srcLinQ <= srcLin;
      dstLinQ <= dstLin;
      xCnt    <= '0;
      yCnt    <= dimY;
      active  <= 1'b1;
    end else if (cmd.advance && active) begin
      if (lastStep) active <= 1'b0;
      if (rowEnd) begin
        xCnt <= '0;
        yCnt <= yCnt - 1'b1;
      end else begin
        xCnt <= xCnt + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    blitSide #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_side (
      .clk(clk), .rstN(rstN), .load(cmd.load), .advance(cmd.advance && active),
      .rowEnd(rowEnd), .startAddr(startArr[s]), .linear(linArr[s]),
      .reverse(revQ), .pitch(pitchQ), .curAddr(curArr[s]), .stepAddr(stepArr[s])
    );
  end

  assign srcAddr = curArr[0];
  assign dstAddr = curArr[1];
  assign endDst  = stepArr[1];

  // R3
  walk_bounds_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (yCnt != '0) && (xCnt < widthQ));
endmodule

// File: rtl/blitCtrl.sv
module blitCtrl import blitSeqPkg::*; #(
  parameter int REG_W  = 12,
  parameter int ADDR_W = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [REG_W+IDX_W-1:0] wrData,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [REG_W-1:0]       rdData,
  input  logic                   memReady,
  input  logic                   irqAck,
  input  logic                   lastStep,
  input  logic [ADDR_W-1:0]      endDst,
  output walkCmd_t               cmd,
  output logic                   memValid,
  output logic                   busy,
  output logic                   irq,
  output logic [ADDR_W-1:0]      srcStart,
  output logic [ADDR_W-1:0]      dstStart,
  output logic [REG_W-1:0]       dimX,
  output logic [REG_W-1:0]       dimY,
  output logic [REG_W-1:0]       pitch,
  output logic                   reverse,
  output logic                   srcLin,
  output logic                   dstLin
);
  localparam int WR_W = REG_W + IDX_W;
  localparam logic [REG_W-1:0] GO_MASK = REG_W'(1) << CA_GO;

  logic [REG_W-1:0] regQ [NUM_REGS];
  logic [IDX_W-1:0] wrIdx;
  logic [REG_W-1:0] payload;
  logic startReq, running, acceptWr, startHit, zeroDim, finishWalk, setIrq;

  always_comb begin
    wrIdx      = wrData[WR_W-1 -: IDX_W];
    payload    = wrData[REG_W-1:0];
    busy       = startReq | running;
    acceptWr   = wrEn && (32'(wrIdx) < NUM_REGS) && (!busy || wrIdx == IX_CTLA);
    startHit   = wrEn && !busy &&
                 ((wrIdx == IX_CTLA && payload[CA_GO]) ||
                  (wrIdx == IX_DSTHI && regQ[IX_CTLB][CB_QUICK]));
    zeroDim    = (regQ[IX_WIDTH] == '0) || (regQ[IX_HEIGHT] == '0);
    finishWalk = running && memReady && lastStep;
    setIrq     = regQ[IX_CTLB][CB_IRQEN] && ((startReq && zeroDim) || finishWalk);
    cmd.load    = startReq && !zeroDim;
    cmd.advance = running && memReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
      startReq <= 1'b0;
      running  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (acceptWr && 32'(wrIdx) == i)
          regQ[i] <= (i == 0) ? (payload & ~GO_MASK) : payload;
      if (finishWalk && regQ[IX_CTLB][CB_UPD]) begin
        regQ[IX_DSTLO] <= endDst[REG_W-1:0];
        regQ[IX_DSTHI] <= endDst[ADDR_W-1:REG_W];
      end
      startReq <= startHit;
      if (cmd.load) running <= 1'b1;
      else if (finishWalk) running <= 1'b0;
      if (setIrq) irq <= 1'b1;
      else if (irqAck) irq <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdIdx == IX_CTLA) rdData = {busy, regQ[IX_CTLA][REG_W-2:0]};
    else if (32'(rdIdx) < NUM_REGS) rdData = regQ[rdIdx];
  end

  assign memValid = running;
  assign srcStart = {regQ[IX_SRCHI], regQ[IX_SRCLO]};
  assign dstStart = {regQ[IX_DSTHI], regQ[IX_DSTLO]};
  assign dimX     = regQ[IX_WIDTH];
  assign dimY     = regQ[IX_HEIGHT];
  assign pitch    = regQ[IX_PITCH];
  assign reverse  = regQ[IX_CTLA][CA_REV];
  assign srcLin   = regQ[IX_CTLA][CA_SLIN];
  assign dstLin   = regQ[IX_CTLA][CA_DLIN];

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqAck |=> irq);
  // R9
  frozen_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && wrEn && wrIdx != IX_CTLA |=>
      $stable(regQ[IX_WIDTH]) && $stable(regQ[IX_HEIGHT]) &&
      $stable(regQ[IX_PITCH]) && $stable(regQ[IX_SRCLO]) && $stable(regQ[IX_SRCHI]));
  // R10
  zero_dim_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq && zeroDim |=> !memValid && !busy);
endmodule

// File: rtl/blitSeq.sv
module blitSeq import blitSeqPkg::*; #(
  parameter int REG_W = 12,
  parameter int ADDR_W = 2 * REG_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [REG_W+IDX_W-1:0] wrData,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [REG_W-1:0]       rdData,
  output logic                   memValid,
  input  logic                   memReady,
  output logic [ADDR_W-1:0]      srcAddr,
  output logic [ADDR_W-1:0]      dstAddr,
  output logic                   busy,
  output logic                   irq,
  input  logic                   irqAck
);
  walkCmd_t cmd;
  logic [ADDR_W-1:0] srcStart, dstStart, endDst;
  logic [REG_W-1:0] dimX, dimY, pitch;
  logic reverse, srcLin, dstLin, lastStep;

  blitCtrl #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdIdx(rdIdx),
    .rdData(rdData), .memReady(memReady), .irqAck(irqAck), .lastStep(lastStep),
    .endDst(endDst), .cmd(cmd), .memValid(memValid), .busy(busy), .irq(irq),
    .srcStart(srcStart), .dstStart(dstStart), .dimX(dimX), .dimY(dimY),
    .pitch(pitch), .reverse(reverse), .srcLin(srcLin), .dstLin(dstLin)
  );

  blitWalk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rstN(rstN), .cmd(cmd), .srcStart(srcStart), .dstStart(dstStart),
    .dimX(dimX), .dimY(dimY), .pitch(pitch), .reverse(reverse), .srcLin(srcLin),
    .dstLin(dstLin), .srcAddr(srcAddr), .dstAddr(dstAddr), .lastStep(lastStep),
    .endDst(endDst)
  );

  // R11
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(srcAddr) && $stable(dstAddr));
endmodule

// File: tb/blitSeq_bench.sv
module blitSeq_bench;
  logic clk = 1'b0;
  logic rstN, wrEn, memReady, irqAck;
  logic [15:0] wrData;
  logic [3:0]  rdIdx;
  logic [11:0] rdData;
  logic memValid, busy, irq;
  logic [23:0] srcAddr, dstAddr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  blitSeq u_blitSeq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdIdx(rdIdx),
    .rdData(rdData), .memValid(memValid), .memReady(memReady), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .busy(busy), .irq(irq), .irqAck(irqAck)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [11:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrData = {idx, val};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [11:0] val);
    rdIdx = idx; #1; val = rdData;
  endtask

  function automatic logic [23:0] expAddr(input logic [23:0] st, input bit rev, input bit lin,
                                          input int w, input int p, input int k);
    int off;
    off = lin ? k : (k / w) * p + (k % w);
    return rev ? st - 24'(off) : st + 24'(off);
  endfunction

  task automatic runBlit(input logic [23:0] src, input logic [23:0] dst, input int w, input int h,
                         input int p, input bit rev, input bit slin, input bit dlin,
                         input bit quick, input bit upd, input bit irqEn);
    logic [11:0] v;
    logic [11:0] flags;
    logic [23:0] endD;
    int total, k, cyc;
    bit stalled;
    string modeTag;
    flags = {1'b0, rev, 2'b00, dlin, slin, 6'd0};
    total = w * h;
    modeTag = rev ? "R4" : ((slin || dlin) ? "R5" : "R3");
    wr(4'd0, flags);
    wr(4'd1, {1'b0, irqEn, 2'b00, quick, upd, 6'd0});
    wr(4'd2, src[11:0]); wr(4'd3, src[23:12]);
    wr(4'd6, 12'(w)); wr(4'd7, 12'(h)); wr(4'd8, 12'(p));
    wr(4'd4, dst[11:0]); wr(4'd5, dst[23:12]);
    if (!quick) begin
      check("R6", "no start without quick bit", {31'd0, busy}, 32'd0);
      wr(4'd0, flags | 12'h800);
    end
    check("R2", "busy after start", {31'd0, busy}, 32'd1);
    rd(4'd0, v);
    check("R2", "go bit reads busy", {20'd0, v}, {20'd0, flags | 12'h800});
    k = 0; cyc = 0; stalled = 1'b0;
    while (busy && cyc < 2000) begin
      memReady = ($urandom % 10) < 7;
      wrEn = (cyc == 1);
      case ($urandom % 4)
        0: wrData = {4'd2, 12'hF0F};
        1: wrData = {4'd6, 12'h777};
        2: wrData = {4'd7, 12'h0};
        default: wrData = {4'd8, 12'h3A5};
      endcase
      #1;
      if (memValid) begin
        if (k >= total) begin
          check("R11", "extra step offered", {31'd0, memValid}, 32'd0);
        end else begin
          check(stalled ? "R11" : modeTag, "src addr", {8'd0, srcAddr}, {8'd0, expAddr(src, rev, slin, w, p, k)});
          check(stalled ? "R11" : modeTag, "dst addr", {8'd0, dstAddr}, {8'd0, expAddr(dst, rev, dlin, w, p, k)});
        end
        stalled = !memReady;
        if (memReady) k++;
      end
      @(negedge clk);
      cyc++;
    end
    wrEn = 1'b0; memReady = 1'b0;
    check(total == 0 ? "R10" : "R11", "step count", k, total);
    if (total == 0) check("R10", "zero-size finish time", cyc, 1);
    check("R2", "busy cleared", {31'd0, busy}, 32'd0);
    endD = (upd && total > 0) ?
           (rev ? expAddr(dst, rev, dlin, w, p, total - 1) - 24'd1
                : expAddr(dst, rev, dlin, w, p, total - 1) + 24'd1) : dst;
    rd(4'd4, v); check("R7", "dst low after run", {20'd0, v}, {20'd0, endD[11:0]});
    rd(4'd5, v); check("R7", "dst high after run", {20'd0, v}, {20'd0, endD[23:12]});
    rd(4'd2, v); check("R9", "src low kept", {20'd0, v}, {20'd0, src[11:0]});
    rd(4'd6, v); check("R9", "width kept", {20'd0, v}, w);
    rd(4'd7, v); check("R9", "height kept", {20'd0, v}, h);
    rd(4'd8, v); check("R9", "pitch kept", {20'd0, v}, p);
    check("R8", "irq at finish", {31'd0, irq}, {31'd0, irqEn});
    repeat (3) @(negedge clk);
    check("R8", "irq sticky", {31'd0, irq}, {31'd0, irqEn});
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    check("R8", "irq cleared by ack", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] v;
    void'($urandom(32'd4242));
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; rdIdx = '0; memReady = 1'b0; irqAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", "reset busy", {31'd0, busy}, 32'd0);
    check("R8", "reset irq", {31'd0, irq}, 32'd0);
    check("R11", "reset valid", {31'd0, memValid}, 32'd0);
    rd(4'd0, v); check("R1", "reset control A", {20'd0, v}, 32'd0);
    // R1 readback of each data register, unmapped index ignored
    for (int i = 2; i <= 8; i++) begin
      if (i == 5) continue;
      wr(4'(i), 12'(12'h111 * i));
      rd(4'(i), v);
      check("R1", "readback", {20'd0, v}, {20'd0, 12'(12'h111 * i)});
    end
    wr(4'd12, 12'hABC);
    rd(4'd12, v); check("R1", "unmapped reads zero", {20'd0, v}, 32'd0);
    rd(4'd8, v); check("R1", "unmapped write ignored", {20'd0, v}, 32'h888);
    // directed cases
    runBlit(24'h001000, 24'h020000, 3, 2, 10, 0, 0, 0, 0, 0, 1);
    runBlit(24'h001000, 24'h020000, 4, 3, 16, 1, 0, 0, 0, 1, 0);
    runBlit(24'h000002, 24'hFFFFFE, 3, 3, 20, 0, 1, 1, 1, 1, 1);
    runBlit(24'h000001, 24'h000003, 2, 3, 8, 1, 1, 0, 1, 1, 1);
    runBlit(24'h123456, 24'h654321, 0, 4, 8, 0, 0, 0, 1, 1, 1);
    runBlit(24'h123456, 24'h654321, 5, 0, 8, 0, 0, 0, 0, 1, 0);
    runBlit(24'h000100, 24'h000200, 1, 1, 0, 0, 0, 1, 0, 1, 1);
    // constrained random
    for (int n = 0; n < 40; n++) begin
      int w, h;
      w = (($urandom % 8) == 0) ? 0 : 1 + ($urandom % 5);
      h = (($urandom % 8) == 0) ? 0 : 1 + ($urandom % 5);
      runBlit(24'($urandom), 24'($urandom), w, h, $urandom % 41,
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule